// File: doc/BRIEF.md
# Dual-Input Running Argmax Unit

This unit watches a frame of signed numbers that arrives two elements per accepted cycle and keeps two results: the largest value seen so far in the frame and the position of the element that produced it. A typical use is to pick the winning class from the last layer of a neural network, so that the scores never have to be read out and sorted in software.

Each beat is reduced in two steps. The two lanes are first compared with each other. The larger of the pair is then compared with the stored maximum. A start strobe opens a new frame. The beat flagged as last closes the frame with a one-cycle done pulse, and the results then stay fixed until the next start.

Top module: `argmax_stream_top`

## Requirements
- R1: After reset, `max_o` is the most negative value (0x8000 at the default 16-bit width), `idx_o` is 0 and `done_o` is 0. A frame is open with its element count at zero, so beats may be fed without a start strobe.
- R2: Within one beat, lane 1 (`data1_i`) is the pair winner only when it is strictly greater than lane 0 (`data0_i`). On equal values, lane 0 wins.
- R3: The pair winner replaces the stored maximum only when it is strictly greater. On a tie, the stored value and the earlier index stay.
- R4: Every comparison treats data as two's-complement signed, so 0x7FFF is the largest value and 0x8000 the smallest.
- R5: Element indices start at 0 in each frame. On the k-th accepted beat (counting from 0), lane 0 has index 2k and lane 1 has index 2k+1. Indices wrap modulo 2^IDX_W.
- R6: In a cycle with `valid_i` and `start_i` both low, `max_o`, `idx_o` and the element count do not change.
- R7: `start_i` sets the maximum to the most negative value and the index and element count to 0. If `valid_i` is high in the same cycle, that beat is taken as beat 0 of the new frame.
- R8: Each accepted beat changes `max_o` and `idx_o` after the next clock edge. When the accepted beat carries `last_i`, `done_o` is high for exactly that one following cycle.
- R9: Once the last beat has been accepted, further beats without `start_i` are ignored, and `max_o` and `idx_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Clears the running result and opens a new frame |
| valid_i | input | 1 | Marks a beat carrying two elements |
| data0_i | input | DATA_W | Signed element for the even index of the beat |
| data1_i | input | DATA_W | Signed element for the odd index of the beat |
| last_i | input | 1 | Marks the final beat of the frame |
| max_o | output | DATA_W | Largest signed value of the frame so far |
| idx_o | output | IDX_W | Element index of `max_o` |
| done_o | output | 1 | One-cycle pulse after the last beat has been accepted |

## Verification
The hardest cases to reach are the tie orderings. The pair winner can equal the stored maximum while a later index sits on the losing side. This has to happen in the same beat as a start or after a frame has closed, so that the priority between the start, the tie rule and the closed-frame rule all decide the result together. A hand-built vector table steps through these cases one beat at a time. These include a beat arriving together with a start, a beat arriving after the last beat, equal lanes and lanes at the extreme values. Random frames then copy the stored maximum into either lane and run frames whose values are all negative, all checked against a reference model in the bench.

// File: rtl/argmax_pkg.sv
package argmax_pkg;

  // Which lane of a beat produced the pair winner.
  typedef enum logic {
    LANE_EVEN = 1'b0,
    LANE_ODD  = 1'b1
  } lane_e;

  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_IDX_W  = 8;

endpackage

// File: rtl/argmax_rst_sync.sv
// Two-stage synchronizer: reset asserts asynchronously, releases on clk.
module argmax_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/argmax_pair_sel.sv
// Reduces one beat to a single candidate; lane 0 wins ties.
module argmax_pair_sel
  import argmax_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic signed [DATA_W-1:0] lane0_i,
  input  logic signed [DATA_W-1:0] lane1_i,
  output logic signed [DATA_W-1:0] win_o,
  output lane_e                    lane_o
);

  always_comb begin
    if (lane1_i > lane0_i) begin
      win_o  = lane1_i;
      lane_o = LANE_ODD;
    end else begin
      win_o  = lane0_i;
      lane_o = LANE_EVEN;
    end
  end

endmodule

// File: rtl/argmax_frame_ctl.sv
// Frame bookkeeping: acceptance, beat counter, open/closed state, done pulse.
module argmax_frame_ctl #(
  parameter int unsigned BEAT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic              last_i,
  output logic              accept_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              done_o
);

  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              open_q, open_d;
  logic              done_q, done_d;
  logic              beat_en;

  // A start reopens the frame in the same cycle, so a beat there is beat 0.
  assign accept_o = valid_i && (open_q || start_i);
  assign beat_o   = start_i ? '0 : beat_q;
  assign beat_en  = accept_o || start_i;

  always_comb begin
    beat_d = beat_q;
    if (beat_en) begin
      beat_d = accept_o ? beat_o + 1'b1 : '0;
    end
  end

  always_comb begin
    open_d = open_q;
    if (accept_o && last_i) begin
      open_d = 1'b0;
    end else if (start_i) begin
      open_d = 1'b1;
    end
  end

  assign done_d = accept_o && last_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      open_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      if (beat_en) begin
        beat_q <= beat_d;
      end
      open_q <= open_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

endmodule

// File: rtl/argmax_track_reg.sv
// Holds the running maximum and its index.
module argmax_track_reg
  import argmax_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned IDX_W  = DEF_IDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     accept_i,
  input  logic signed [DATA_W-1:0] cand_i,
  input  logic [IDX_W-1:0]         cand_idx_i,
  output logic signed [DATA_W-1:0] max_o,
  output logic [IDX_W-1:0]         idx_o
);

  localparam logic signed [DATA_W-1:0] MIN_VAL = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] max_q, max_d, base_max;
  logic [IDX_W-1:0]         idx_q, idx_d, base_idx;
  logic                     take;
  logic                     reg_en;

  // The start cycle compares against a cleared baseline.
  assign base_max = start_i ? MIN_VAL : max_q;
  assign base_idx = start_i ? '0 : idx_q;
  assign take     = accept_i && (cand_i > base_max);
  assign reg_en   = start_i || take;

  always_comb begin
    max_d = base_max;
    idx_d = base_idx;
    if (take) begin
      max_d = cand_i;
      idx_d = cand_idx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q <= MIN_VAL;
      idx_q <= '0;
    end else if (reg_en) begin
      max_q <= max_d;
      idx_q <= idx_d;
    end
  end

  assign max_o = max_q;
  assign idx_o = idx_q;

endmodule

// File: rtl/argmax_stream_top.sv
module argmax_stream_top
  import argmax_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned IDX_W  = DEF_IDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] data0_i,
  input  logic signed [DATA_W-1:0] data1_i,
  input  logic                     last_i,
  output logic signed [DATA_W-1:0] max_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic                     done_o
);

  // Indices are always {beat, lane}: the counter stores only the beat.
  localparam int unsigned BEAT_W = IDX_W - 1;

  logic                     rst_sync_n;
  logic                     accept;
  logic [BEAT_W-1:0]        beat;
  logic signed [DATA_W-1:0] pair_win;
  lane_e                    pair_lane;
  logic [IDX_W-1:0]         cand_idx;

  argmax_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  argmax_pair_sel #(.DATA_W(DATA_W)) u_pair (
    .lane0_i (data0_i),
    .lane1_i (data1_i),
    .win_o   (pair_win),
    .lane_o  (pair_lane)
  );

  argmax_frame_ctl #(.BEAT_W(BEAT_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .valid_i  (valid_i),
    .last_i   (last_i),
    .accept_o (accept),
    .beat_o   (beat),
    .done_o   (done_o)
  );

  assign cand_idx = {beat, pair_lane == LANE_ODD};

  argmax_track_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .accept_i   (accept),
    .cand_i     (pair_win),
    .cand_idx_i (cand_idx),
    .max_o      (max_o),
    .idx_o      (idx_o)
  );

endmodule

// File: rtl/argmax_stream_chk.sv
module argmax_stream_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start_i,
  input logic                     valid_i,
  input logic                     last_i,
  input logic signed [DATA_W-1:0] max_o,
  input logic [IDX_W-1:0]         idx_o,
  input logic                     done_o
);

  localparam logic signed [DATA_W-1:0] MIN_VAL = {1'b1, {(DATA_W-1){1'b0}}};

  // R6: an idle cycle leaves the result untouched
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !start_i) |=> ($stable(max_o) && $stable(idx_o)));

  // R3: inside a frame the maximum never falls
  p_max_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i) |=> ($signed(max_o) >= $signed($past(max_o))));

  // R7: a start without a beat leaves the cleared baseline
  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !valid_i) |=> (max_o == MIN_VAL && idx_o == '0));

  // R8: done only follows a beat flagged as last
  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(valid_i && last_i));

  // R9: after the closing beat the result holds until a start
  p_closed_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> ($stable(max_o) && $stable(idx_o)));

endmodule

bind argmax_stream_top argmax_stream_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start_i (start_i),
  .valid_i (valid_i),
  .last_i  (last_i),
  .max_o   (max_o),
  .idx_o   (idx_o),
  .done_o  (done_o)
);

// File: tb/argmax_stream_top_bench.sv
module argmax_stream_top_bench;

  localparam int DW = 16;
  localparam int IW = 8;
  localparam logic signed [DW-1:0] MINV = 16'sh8000;

  typedef struct packed {
    logic                 start;
    logic                 valid;
    logic                 last;
    logic signed [DW-1:0] d0;
    logic signed [DW-1:0] d1;
    logic signed [DW-1:0] emax;
    logic [IW-1:0]        eidx;
    logic                 edone;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0,  16'sd0,     16'sd0,      MINV,        8'd0, 1'b0},
    '{1'b0, 1'b1, 1'b0,  16'sd5,    -16'sd3,      16'sd5,      8'd0, 1'b0},
    '{1'b0, 1'b1, 1'b0, -16'sd7,     16'sd9,      16'sd9,      8'd3, 1'b0},
    '{1'b0, 1'b0, 1'b0,  16'sd100,   16'sd100,    16'sd9,      8'd3, 1'b0},
    '{1'b0, 1'b1, 1'b0,  16'sd9,     16'sd9,      16'sd9,      8'd3, 1'b0},
    '{1'b0, 1'b1, 1'b1, -16'sd1,     16'sd12,     16'sd12,     8'd7, 1'b1},
    '{1'b0, 1'b1, 1'b0,  16'sd500,   16'sd0,      16'sd12,     8'd7, 1'b0},
    '{1'b1, 1'b1, 1'b0, -16'sd20,   -16'sd10,    -16'sd10,     8'd1, 1'b0},
    '{1'b0, 1'b1, 1'b0, -16'sd10,   -16'sd30,    -16'sd10,     8'd1, 1'b0},
    '{1'b0, 1'b1, 1'b1,  MINV,       MINV,       -16'sd10,     8'd1, 1'b1},
    '{1'b1, 1'b1, 1'b1,  MINV,       MINV,        MINV,        8'd0, 1'b1},
    '{1'b1, 1'b1, 1'b0,  16'sh7FFF, -16'sd1,      16'sh7FFF,   8'd0, 1'b0},
    '{1'b0, 1'b1, 1'b0,  MINV,       16'sh7FFF,   16'sh7FFF,   8'd0, 1'b0},
    '{1'b0, 1'b0, 1'b0,  16'sd0,     16'sd0,      16'sh7FFF,   8'd0, 1'b0}
  };

  function automatic string row_tag(input int i);
    case (i)
      0:       return "R7 start clears";
      1:       return "R2 lane0 larger";
      2:       return "R5 lane1 index 3";
      3:       return "R6 idle freezes";
      4:       return "R3 tie keeps earlier";
      5:       return "R8 last gives done";
      6:       return "R9 beat after last ignored";
      7:       return "R7 start with beat";
      8:       return "R3 negative tie";
      9:       return "R4 most negative loses";
      10:      return "R2 lane tie on start";
      11:      return "R4 signed extremes";
      12:      return "R4 max positive held";
      default: return "R8 done single cycle";
    endcase
  endfunction

  logic                 clk;
  logic                 rst_n;
  logic                 start_i, valid_i, last_i;
  logic signed [DW-1:0] data0_i, data1_i;
  logic signed [DW-1:0] max_o;
  logic [IW-1:0]        idx_o;
  logic                 done_o;

  int n_chk;
  int n_bad;
  bit finished;

  argmax_stream_top #(.DATA_W(DW), .IDX_W(IW)) u_argmax_stream_top (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .valid_i (valid_i),
    .data0_i (data0_i),
    .data1_i (data1_i),
    .last_i  (last_i),
    .max_o   (max_o),
    .idx_o   (idx_o),
    .done_o  (done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic signed [DW-1:0] emax,
                       input logic [IW-1:0] eidx, input logic edone);
    n_chk++;
    if (max_o !== emax || idx_o !== eidx || done_o !== edone) begin
      n_bad++;
      $display("FAIL %s: max=%0d idx=%0d done=%0b expected max=%0d idx=%0d done=%0b",
               tag, max_o, idx_o, done_o, emax, eidx, edone);
    end
  endtask

  // Drive on the falling edge, sample 5 ns after the next rising edge.
  task automatic beat(input logic s, input logic v, input logic l,
                      input logic signed [DW-1:0] a, input logic signed [DW-1:0] b);
    @(negedge clk);
    start_i = s; valid_i = v; last_i = l; data0_i = a; data1_i = b;
    @(posedge clk);
    #5;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    start_i = 0; valid_i = 0; last_i = 0; data0_i = '0; data1_i = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset state", MINV, 8'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: the frame is open after reset, so a beat without start counts as beat 0
    beat(0, 1, 0, -16'sd4, -16'sd2);
    check("R1 open after reset", -16'sd2, 8'd1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      beat(VEC[i].start, VEC[i].valid, VEC[i].last, VEC[i].d0, VEC[i].d1);
      check(row_tag(i), VEC[i].emax, VEC[i].eidx, VEC[i].edone);
    end

    // R1: reset asserted mid-frame takes effect without a clock edge
    @(negedge clk);
    rst_n = 1'b0;
    #5;
    check("R1 async reset", MINV, 8'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    valid_i = 0; start_i = 0;
    repeat (3) @(posedge clk);

    // Random frames against a reference model (R2, R3, R4, R5, R8)
    void'($urandom(32'd7));
    for (int f = 0; f < 60; f++) begin
      logic signed [DW-1:0] rmax;
      logic [IW-1:0] ridx;
      int k;
      int len;
      bit allneg;
      len = 1 + int'($urandom % 20);
      allneg = ($urandom % 3) == 0;
      beat(1, 0, 0, 16'sd0, 16'sd0);
      rmax = MINV; ridx = '0; k = 0;
      check("R7 frame clear", rmax, ridx, 1'b0);
      while (k < len) begin
        logic signed [DW-1:0] a;
        logic signed [DW-1:0] b;
        logic signed [DW-1:0] w;
        logic [IW-1:0] wi;
        int mode;
        bit lst;
        if (($urandom % 4) == 0) begin
          beat(0, 0, 0, DW'($urandom), DW'($urandom));
          check("R6 random idle", rmax, ridx, 1'b0);
          continue;
        end
        a = DW'($urandom);
        b = DW'($urandom);
        if (allneg) begin
          a = a | MINV;
          b = b | MINV;
        end
        mode = int'($urandom % 5);
        if (mode == 0) b = a;
        if (mode == 1 && k > 0) a = rmax;
        if (mode == 2 && k > 0) b = rmax;
        lst = (k == len - 1);
        w  = (b > a) ? b : a;
        wi = IW'((b > a) ? 2 * k + 1 : 2 * k);
        if (w > rmax) begin
          rmax = w;
          ridx = wi;
        end
        beat(0, 1, lst, a, b);
        check("R5 random frame", rmax, ridx, lst);
        k++;
      end
    end

    beat(0, 0, 0, 16'sd0, 16'sd0);
    finish_run();
  end

endmodule